// File: doc/BRIEF.md
# Two-Stage Pipelined Signed Multiply-Accumulate

This unit multiplies pairs of signed operands and sums the products into a wide accumulator, so that a stream of pairs yields their signed dot product. The multiply is not done in one cycle. In the first stage each operand is cut into a signed upper half and an unsigned lower half, and the four cross products of those halves are registered. In the second stage the registered partial products are shifted, summed into the full product and added to the accumulator in the same cycle.

A new pair may be offered every cycle together with a valid strobe; slots without the strobe pass through without touching the sum. A synchronous clear restarts the sum. A product already in the pipeline when the clear arrives is not lost; it becomes the first term of the new sum. The unit is meant to sit behind an operand source that has already fetched and aligned its data; scaling of the result is left to the consumer.

Top module: `split_mac`

## Requirements
- R1: While reset (rstN low) is held and at the first cycle after it, accOut is zero and resultValid is low.
- R2: A pair sampled with opValid high at clock edge k changes accOut only at edge k+1, not at edge k; resultValid is high during the cycle after edge k+1 and low after it unless another pair followed.
- R3: The product is the exact signed product of the two 32-bit two's-complement operands: 0x80000000 times 0x80000000 gives 0x4000000000000000, 0x80000000 times 1 gives 0xFFFFFFFF80000000, and zero times anything gives zero.
- R4: Pairs may be offered on consecutive cycles, with or without gaps; after the last one has drained, accOut equals the signed sum of all their products since the last clear.
- R5: A cycle with opValid low leaves accOut unchanged two edges later whatever opA and opB carry, and produces no resultValid pulse.
- R6: accClear sampled high at an edge sets accOut to zero, plus the product of a pair sampled at the previous edge if there was one; a pair sampled together with the clear is added at the following edge.
- R7: The accumulator wraps modulo 2^64 with no saturation: two additions of 2^62 give 0x8000000000000000 and four give zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| opValid | input | 1 | Marks opA/opB as a pair to accumulate |
| opA | input | 32 | First signed operand |
| opB | input | 32 | Second signed operand |
| accClear | input | 1 | Synchronous accumulator clear |
| accOut | output | 64 | Current accumulator value |
| resultValid | output | 1 | High for one cycle after a product has been added |

## Verification
On every cycle the assertions check that the recombined partial products equal a full-width signed multiply of the operands captured one edge earlier, that a clear with nothing in flight leaves zero, that an empty slot leaves the sum unchanged, and that a valid pair always, and an empty slot never, produces a result pulse two edges later. Wrap-around of the sum, the ordering of a clear against an in-flight product, and the final value of long streams with gaps are shown only by the bench scenarios, compared each cycle against a behavioural model.

// File: rtl/smac_pkg.sv
package smac_pkg;

  // Strobes passed from the sequencing logic to the arithmetic datapath.
  typedef struct packed {
    logic capture;  // register partial products of the current operands
    logic absorb;   // stage two holds a live product to add
    logic wipe;     // restart the sum this edge
  } smacStrobe_t;

endpackage

// File: rtl/smac_ctrl.sv
module smac_ctrl
  import smac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic        accClear,
  output smacStrobe_t strobe,
  output logic        resultValid
);

  logic stage1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      stage1Valid <= opValid;
      resultValid <= stage1Valid;
    end
  end

  always_comb begin
    strobe.capture = opValid;
    strobe.absorb  = stage1Valid;
    strobe.wipe    = accClear;
  end

  // R2
  latency_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> ##1 resultValid);

  // R5
  empty_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ##1 !resultValid);

endmodule

// File: rtl/smac_data.sv
module smac_data
  import smac_pkg::*;
#(
  parameter int OPW  = 32,
  parameter int ACCW = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  smacStrobe_t     strobe,
  input  logic [OPW-1:0]  opA,
  input  logic [OPW-1:0]  opB,
  output logic [ACCW-1:0] accOut
);

  localparam int HW = OPW / 2;
  localparam int PW = 2 * HW;

  // Operand halves: upper signed, lower unsigned.
  logic signed [HW-1:0] aHi, bHi;
  logic        [HW-1:0] aLo, bLo;

  // Stage-one partial products (next and registered).
  logic        [PW-1:0] llD, llQ;
  logic signed [PW:0]   lhD, lhQ, hlD, hlQ;
  logic signed [PW-1:0] hhD, hhQ;

  // Stage-two recombination.
  logic signed [ACCW-1:0] hhX, lhX, hlX, llX, product;
  logic        [ACCW-1:0] accQ;

  always_comb begin
    aHi = $signed(opA[OPW-1:HW]);
    bHi = $signed(opB[OPW-1:HW]);
    aLo = opA[HW-1:0];
    bLo = opB[HW-1:0];
    llD = PW'(aLo) * PW'(bLo);
    lhD = $signed({1'b0, aLo}) * bHi;
    hlD = aHi * $signed({1'b0, bLo});
    hhD = aHi * bHi;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      llQ <= '0;
      lhQ <= '0;
      hlQ <= '0;
      hhQ <= '0;
    end else if (strobe.capture) begin
      llQ <= llD;
      lhQ <= lhD;
      hlQ <= hlD;
      hhQ <= hhD;
    end
  end

  always_comb begin
    hhX     = ACCW'(hhQ);
    lhX     = ACCW'(lhQ);
    hlX     = ACCW'(hlQ);
    llX     = $signed(ACCW'(llQ));
    product = (hhX <<< PW) + ((lhX + hlX) <<< HW) + llX;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (strobe.wipe) begin
      accQ <= strobe.absorb ? product : '0;
    end else if (strobe.absorb) begin
      accQ <= accQ + product;
    end
  end

  assign accOut = accQ;

  // R3
  prod_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.absorb |-> product == $past(ACCW'($signed(opA)) * ACCW'($signed(opB))));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wipe && !strobe.absorb) |=> accQ == '0);

  // R5
  hold_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wipe && !strobe.absorb) |=> $stable(accQ));

endmodule

// File: rtl/split_mac.sv
module split_mac
  import smac_pkg::*;
#(
  parameter int OPW  = 32,
  parameter int ACCW = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [OPW-1:0]  opA,
  input  logic [OPW-1:0]  opB,
  input  logic            accClear,
  output logic [ACCW-1:0] accOut,
  output logic            resultValid
);

  smacStrobe_t strobe;

  smac_ctrl ctrlU (
    .clk         (clk),
    .rstN        (rstN),
    .opValid     (opValid),
    .accClear    (accClear),
    .strobe      (strobe),
    .resultValid (resultValid)
  );

  smac_data #(.OPW(OPW), .ACCW(ACCW)) dataU (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .accOut (accOut)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (accOut == '0 && !resultValid));

endmodule

// File: tb/split_mac_test.sv
module split_mac_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, opValid, accClear, resultValid;
  logic [31:0] opA, opB;
  logic [63:0] accOut;

  split_mac #(.OPW(32), .ACCW(64)) uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opA(opA), .opB(opB),
    .accClear(accClear), .accOut(accOut), .resultValid(resultValid)
  );

  int    total = 0;
  int    bad   = 0;
  string tag   = "R1";

  // Behavioural reference: one in-flight slot, then the sum.
  longint accM;
  bit     rvM;
  bit     pendV;
  longint pendP;

  always @(posedge clk) begin
    if (!rstN) begin
      accM <= 0; rvM <= 0; pendV <= 0; pendP <= 0;
    end else begin
      longint nextAcc;
      nextAcc = accClear ? 64'd0 : accM;
      if (pendV) nextAcc = nextAcc + pendP;
      accM  <= nextAcc;
      rvM   <= pendV;
      pendV <= opValid;
      pendP <= longint'(int'(opA)) * longint'(int'(opB));
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check({tag, " model acc"}, accOut, accM);
    check({tag, " model valid"}, {63'd0, resultValid}, {63'd0, rvM});
  endtask

  task automatic put(bit v, logic [31:0] a, logic [31:0] b, bit c);
    opValid = v; opA = a; opB = b; accClear = c;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint dot;
    rstN = 0; opValid = 0; accClear = 0; opA = '1; opB = '1;
    repeat (3) @(negedge clk);
    check("R1 acc in reset", accOut, 64'd0);
    check("R1 valid in reset", {63'd0, resultValid}, 64'd0);
    rstN = 1;

    // R2: latency
    tag = "R2";
    put(1, 32'd3, -32'sd5, 0);
    check("R2 acc not yet updated", accOut, 64'd0);
    check("R2 no early valid", {63'd0, resultValid}, 64'd0);
    put(0, 0, 0, 0);
    check("R2 acc updated", accOut, -64'sd15);
    check("R2 valid pulse", {63'd0, resultValid}, 64'd1);
    put(0, 0, 0, 0);
    check("R2 valid drops", {63'd0, resultValid}, 64'd0);

    // R3: signed corners
    tag = "R3";
    put(0, 0, 0, 1);
    check("R6 clear idle", accOut, 64'd0);
    put(1, 32'h8000_0000, 32'h8000_0000, 0);
    put(0, 0, 0, 0);
    check("R3 min*min", accOut, 64'h4000_0000_0000_0000);
    put(0, 0, 0, 1);
    put(1, 32'h8000_0000, 32'd1, 0);
    put(0, 0, 0, 0);
    check("R3 min*one", accOut, 64'hFFFF_FFFF_8000_0000);
    put(0, 0, 0, 1);
    put(1, 32'd0, 32'h7FFF_FFFF, 0);
    put(0, 0, 0, 0);
    check("R3 zero operand", accOut, 64'd0);

    // R7: wrap
    tag = "R7";
    put(0, 0, 0, 1);
    put(1, 32'h8000_0000, 32'h8000_0000, 0);
    put(1, 32'h8000_0000, 32'h8000_0000, 0);
    put(1, 32'h8000_0000, 32'h8000_0000, 0);
    check("R7 two terms", accOut, 64'h8000_0000_0000_0000);
    put(1, 32'h8000_0000, 32'h8000_0000, 0);
    check("R7 three terms", accOut, 64'hC000_0000_0000_0000);
    put(0, 0, 0, 0);
    check("R7 four terms wrap", accOut, 64'd0);

    // R6: clear with product in flight
    tag = "R6";
    put(1, 32'd100, 32'd100, 0);
    put(1, 32'd7, 32'd9, 0);
    check("R6 pre-clear sum", accOut, 64'd10000);
    put(1, 32'd2, 32'd3, 1);
    check("R6 in-flight kept", accOut, 64'd63);
    put(0, 0, 0, 0);
    check("R6 pair with clear added", accOut, 64'd69);

    // R5: empty slots with junk operands
    tag = "R5";
    put(0, 32'hDEAD_BEEF, 32'h1234_5678, 0);
    put(0, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    put(0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0);
    check("R5 sum held", accOut, 64'd69);
    check("R5 no pulse", {63'd0, resultValid}, 64'd0);

    // R4: dot product over a stream with gaps
    tag = "R4";
    put(0, 0, 0, 1);
    dot = 0;
    for (int i = 0; i < 60; i++) begin
      bit          v;
      logic [31:0] a, b;
      v = ($urandom_range(0, 4) != 0);
      a = $urandom;
      b = (i % 7 == 0) ? 32'h8000_0000 : $urandom;
      if (v) dot = dot + longint'(int'(a)) * longint'(int'(b));
      put(v, a, b, 0);
    end
    put(0, 0, 0, 0);
    put(0, 0, 0, 0);
    check("R4 dot product", accOut, dot);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule